// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR flash model, written as synchronous logic. Each host write arrives as a one-cycle strobe carrying a word address and a data word. The decoder follows the multi-cycle unlock sequences and issues a one-cycle start pulse for word program, sector erase, block erase, chip erase, erase suspend and erase resume. It also moves between normal read mode, identification mode and query mode.

The storage array reports two inputs back to the decoder: whether an internal operation is running, and whether that operation is an erase. The decoder uses them, together with the write-protect input and its own record of a suspended erase, to drop requests that must not start. Any broken sequence returns the decoder to read mode. A granted program or erase also registers the target address and data word for the array.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset all six start pulses are low, `mode` is 0 (read), `susp_active` is 0 and `tgt_addr`/`tgt_data` are zero.
- R2: The writes 05555h/AAh, 02AAAh/55h, 05555h/A0h followed by one write to any address give `prog_go` high for exactly one cycle, in the cycle after that fourth write, with `tgt_addr`/`tgt_data` equal to its address and data word.
- R3: The writes 05555h/AAh, 02AAAh/55h, 05555h/80h, 05555h/AAh, 02AAAh/55h followed by a sixth write of 30h raise `sec_erase_go`, or of 50h raise `blk_erase_go`, one cycle later, with `tgt_addr` equal to the sixth write's address. Only one start pulse is high in any cycle.
- R4: The same five-write prefix followed by 10h written to 05555h raises `chip_erase_go` with `tgt_addr` = 05555h; 10h at any other address starts nothing.
- R5: A single write of B0h to any address while `arr_busy` and `arr_erasing` are both high, after a granted sector or block erase, raises `suspend_go` and sets `susp_active`; a B0h write while no erase is running has no effect.
- R6: While `susp_active` is 1 and the array is idle, a single write of 30h to any address raises `resume_go` and clears `susp_active`; `resume_go` never occurs without a suspension.
- R7: The three-write prefix ending with 90h written to 05555h sets `mode` to 1 (identification); ending with 98h sets `mode` to 2 (query); a single write of 98h to 00055h also sets `mode` to 2; a single write of F0h to any address, or the prefix ending with F0h, sets `mode` to 0.
- R8: While `arr_busy` is high every write is ignored, apart from B0h during an erase: no start pulse, no change of `mode`, and a partly entered sequence continues after the busy period as if the write had not been made.
- R9: A write that does not match the expected cycle of an unlock sequence abandons the sequence without a start pulse and sets `mode` to 0.
- R10: With `wp_n` low, a program, sector erase or block erase whose address has bits 19..15 all zero (the protected boot block, BOOT_TOP = 0) starts nothing, and chip erase starts nothing at all; targets outside the boot block proceed.
- R11: Only data bits 7..0 are compared in command cycles; bits 15..8 may hold any value.
- R12: While `susp_active` is 1, a program whose address bits 19..11 equal those of the suspended sector erase, or whose bits 19..15 equal those of the suspended block erase, starts nothing, other addresses are programmed, and any new erase sequence starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Host write cycle present this clock |
| wr_addr | input | 20 | Word address of the host write |
| wr_data | input | 16 | Data word of the host write |
| wp_n | input | 1 | Write protect, low protects the boot block |
| arr_busy | input | 1 | Array is running an internal program or erase |
| arr_erasing | input | 1 | The running internal operation is an erase |
| prog_go | output | 1 | One-cycle word program start |
| sec_erase_go | output | 1 | One-cycle sector erase start |
| blk_erase_go | output | 1 | One-cycle block erase start |
| chip_erase_go | output | 1 | One-cycle chip erase start |
| suspend_go | output | 1 | One-cycle erase suspend request |
| resume_go | output | 1 | One-cycle erase resume request |
| tgt_addr | output | 20 | Address of the last granted program or erase |
| tgt_data | output | 16 | Data word of the last granted program or erase |
| mode | output | 2 | 0 read, 1 identification, 2 query |
| susp_active | output | 1 | An erase is suspended |

## Verification
On every cycle the assertions check several things:
- a write while the array is busy produces no start pulse other than a suspend, and leaves the mode and the sequence position unchanged;
- chip erase never starts while protection is asserted, and no protected boot-block target is ever granted;
- resume follows only a suspension, and a suspension follows only a sector or block erase;
- at most one start pulse is high, and chip erase always reports address 05555h.

Only the bench scenarios can show the rest, because it depends on the exact ordering of writes:
- that each sequence produces the right pulse with the right target;
- that a wrong cycle abandons the sequence;
- that the high data byte is ignored;
- which addresses count as inside the suspended sector or block.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_ID    = 2'd1,
    MODE_QUERY = 2'd2
  } fcd_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PROG, SQ_E1, SQ_E2, SQ_E3
  } fcd_seq_e;

  typedef enum logic [1:0] {
    EK_NONE, EK_SECTOR, EK_BLOCK, EK_CHIP
  } fcd_ekind_e;

  typedef struct packed {
    logic prog;
    logic sec;
    logic blk;
    logic chip;
    logic susp;
    logic resume;
    logic id;
    logic query;
    logic leave;
  } fcd_req_t;

  localparam logic [7:0] CMD_KEY1   = 8'hAA;
  localparam logic [7:0] CMD_KEY2   = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_BLOCK  = 8'h50;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SUSP   = 8'hB0;
  localparam logic [7:0] CMD_RESUME = 8'h30;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_QUERY  = 8'h98;
  localparam logic [7:0] CMD_LEAVE  = 8'hF0;

  // Index of the sector or block that holds an address.
  function automatic logic [31:0] region_of(input logic [31:0] a, input int unsigned lsb);
    return a >> lsb;
  endfunction

  // True when an address falls in the protectable boot block.
  function automatic logic in_boot(input logic [31:0] a, input int unsigned addr_w,
                                   input int unsigned blk_lsb, input logic top);
    logic [31:0] blk;
    logic [31:0] mask;
    blk  = a >> blk_lsb;
    mask = (32'd1 << (addr_w - blk_lsb)) - 32'd1;
    blk  = blk & mask;
    return top ? (blk == mask) : (blk == 32'd0);
  endfunction

endpackage

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        cmd_byte,
  input  logic              arr_busy,
  input  logic              arr_erasing,
  output fcd_req_t          req,
  output logic              seq_abort
);

  localparam logic [ADDR_W-1:0] KEY_A1  = ADDR_W'(32'h5555);
  localparam logic [ADDR_W-1:0] KEY_A2  = ADDR_W'(32'h2AAA);
  localparam logic [ADDR_W-1:0] QUICK_Q = ADDR_W'(32'h0055);

  fcd_seq_e state, nxt;
  logic     cyc_live, at_a1, at_a2, at_q;

  assign cyc_live = wr_valid && !arr_busy;
  assign at_a1    = (wr_addr == KEY_A1);
  assign at_a2    = (wr_addr == KEY_A2);
  assign at_q     = (wr_addr == QUICK_Q);

  always_comb begin
    nxt       = state;
    req       = '0;
    seq_abort = 1'b0;
    if (wr_valid && arr_busy && arr_erasing && cmd_byte == CMD_SUSP) req.susp = 1'b1;
    if (cyc_live) begin
      case (state)
        SQ_IDLE: begin
          if (at_a1 && cmd_byte == CMD_KEY1)       nxt = SQ_U1;
          else if (cmd_byte == CMD_LEAVE)          req.leave  = 1'b1;
          else if (at_q && cmd_byte == CMD_QUERY)  req.query  = 1'b1;
          else if (cmd_byte == CMD_RESUME)         req.resume = 1'b1;
        end
        SQ_U1: begin
          if (at_a2 && cmd_byte == CMD_KEY2) nxt = SQ_U2;
          else begin nxt = SQ_IDLE; seq_abort = 1'b1; end
        end
        SQ_U2: begin
          nxt = SQ_IDLE;
          if (!at_a1) seq_abort = 1'b1;
          else begin
            case (cmd_byte)
              CMD_PROG:  nxt = SQ_PROG;
              CMD_ERASE: nxt = SQ_E1;
              CMD_IDENT: req.id    = 1'b1;
              CMD_QUERY: req.query = 1'b1;
              CMD_LEAVE: req.leave = 1'b1;
              default:   seq_abort = 1'b1;
            endcase
          end
        end
        SQ_PROG: begin
          req.prog = 1'b1;
          nxt      = SQ_IDLE;
        end
        SQ_E1: begin
          if (at_a1 && cmd_byte == CMD_KEY1) nxt = SQ_E2;
          else begin nxt = SQ_IDLE; seq_abort = 1'b1; end
        end
        SQ_E2: begin
          if (at_a2 && cmd_byte == CMD_KEY2) nxt = SQ_E3;
          else begin nxt = SQ_IDLE; seq_abort = 1'b1; end
        end
        SQ_E3: begin
          nxt = SQ_IDLE;
          if (cmd_byte == CMD_SECT)                 req.sec  = 1'b1;
          else if (cmd_byte == CMD_BLOCK)           req.blk  = 1'b1;
          else if (at_a1 && cmd_byte == CMD_CHIP)   req.chip = 1'b1;
          else                                      seq_abort = 1'b1;
        end
        default: nxt = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= nxt;
  end

  AST_SEQ_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && arr_busy) |=> (state == $past(state))); // R8

  AST_ABORT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |-> !(req.prog || req.sec || req.blk || req.chip)); // R9

endmodule

// File: rtl/fcd_guard.sv
module fcd_guard
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned SECTOR_LSB = 11,
  parameter int unsigned BLOCK_LSB  = 15,
  parameter bit          BOOT_TOP   = 1'b0
) (
  input  fcd_req_t          req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wp_n,
  input  logic              susp_active,
  input  fcd_ekind_e        erase_kind,
  input  logic [ADDR_W-1:0] erase_addr,
  output fcd_req_t          grant,
  output logic              drop_wp,
  output logic              drop_susp
);

  logic boot_hit, same_sec, same_blk, susp_clash, prot;

  assign boot_hit = in_boot(32'(wr_addr), ADDR_W, BLOCK_LSB, BOOT_TOP);
  assign same_sec = region_of(32'(wr_addr), SECTOR_LSB) == region_of(32'(erase_addr), SECTOR_LSB);
  assign same_blk = region_of(32'(wr_addr), BLOCK_LSB)  == region_of(32'(erase_addr), BLOCK_LSB);
  assign susp_clash = susp_active &&
                      ((erase_kind == EK_SECTOR && same_sec) || (erase_kind == EK_BLOCK && same_blk));
  assign prot = !wp_n && boot_hit;

  always_comb begin
    grant        = req;
    grant.prog   = req.prog && !prot && !susp_clash;
    grant.sec    = req.sec  && !prot && !susp_active;
    grant.blk    = req.blk  && !prot && !susp_active;
    grant.chip   = req.chip && wp_n  && !susp_active;
    grant.susp   = req.susp && !susp_active &&
                   (erase_kind == EK_SECTOR || erase_kind == EK_BLOCK);
    grant.resume = req.resume && susp_active;
  end

  assign drop_wp   = ((req.prog || req.sec || req.blk) && prot) || (req.chip && !wp_n);
  assign drop_susp = (req.prog && susp_clash) || ((req.sec || req.blk || req.chip) && susp_active);

endmodule

// File: rtl/fcd_mode_ctl.sv
module fcd_mode_ctl
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fcd_req_t          grant,
  input  logic              seq_abort,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              prog_go,
  output logic              sec_erase_go,
  output logic              blk_erase_go,
  output logic              chip_erase_go,
  output logic              suspend_go,
  output logic              resume_go,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_data,
  output fcd_mode_e         mode,
  output logic              susp_active,
  output fcd_ekind_e        erase_kind,
  output logic [ADDR_W-1:0] erase_addr
);

  logic starts_op;
  assign starts_op = grant.prog || grant.sec || grant.blk || grant.chip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_go       <= 1'b0;
      sec_erase_go  <= 1'b0;
      blk_erase_go  <= 1'b0;
      chip_erase_go <= 1'b0;
      suspend_go    <= 1'b0;
      resume_go     <= 1'b0;
      tgt_addr      <= '0;
      tgt_data      <= '0;
      mode          <= MODE_READ;
      susp_active   <= 1'b0;
      erase_kind    <= EK_NONE;
      erase_addr    <= '0;
    end else begin
      prog_go       <= grant.prog;
      sec_erase_go  <= grant.sec;
      blk_erase_go  <= grant.blk;
      chip_erase_go <= grant.chip;
      suspend_go    <= grant.susp;
      resume_go     <= grant.resume;
      if (starts_op) begin
        tgt_addr <= wr_addr;
        tgt_data <= wr_data;
      end
      if (grant.sec)       begin erase_kind <= EK_SECTOR; erase_addr <= wr_addr; end
      else if (grant.blk)  begin erase_kind <= EK_BLOCK;  erase_addr <= wr_addr; end
      else if (grant.chip) begin erase_kind <= EK_CHIP;   erase_addr <= wr_addr; end
      if (grant.susp)        susp_active <= 1'b1;
      else if (grant.resume) susp_active <= 1'b0;
      if (grant.id)                        mode <= MODE_ID;
      else if (grant.query)                mode <= MODE_QUERY;
      else if (grant.leave || seq_abort)   mode <= MODE_READ;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_go, sec_erase_go, blk_erase_go, chip_erase_go, suspend_go, resume_go})); // R3

  AST_SUSP_AFTER_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_active) |-> (erase_kind == EK_SECTOR || erase_kind == EK_BLOCK)); // R5

  AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    resume_go |-> !susp_active); // R6

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned SECTOR_LSB = 11,
  parameter int unsigned BLOCK_LSB  = 15,
  parameter bit          BOOT_TOP   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wp_n,
  input  logic              arr_busy,
  input  logic              arr_erasing,
  output logic              prog_go,
  output logic              sec_erase_go,
  output logic              blk_erase_go,
  output logic              chip_erase_go,
  output logic              suspend_go,
  output logic              resume_go,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_data,
  output logic [1:0]        mode,
  output logic              susp_active
);

  localparam logic [ADDR_W-1:0] CHIP_A = ADDR_W'(32'h5555);

  fcd_req_t          req, grant;
  logic              seq_abort, drop_wp, drop_susp;
  fcd_ekind_e        erase_kind;
  logic [ADDR_W-1:0] erase_addr;
  fcd_mode_e         mode_q;

  fcd_seq_fsm #(.ADDR_W(ADDR_W)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .cmd_byte    (wr_data[7:0]),
    .arr_busy    (arr_busy),
    .arr_erasing (arr_erasing),
    .req         (req),
    .seq_abort   (seq_abort)
  );

  fcd_guard #(
    .ADDR_W(ADDR_W), .SECTOR_LSB(SECTOR_LSB), .BLOCK_LSB(BLOCK_LSB), .BOOT_TOP(BOOT_TOP)
  ) i_guard (
    .req         (req),
    .wr_addr     (wr_addr),
    .wp_n        (wp_n),
    .susp_active (susp_active),
    .erase_kind  (erase_kind),
    .erase_addr  (erase_addr),
    .grant       (grant),
    .drop_wp     (drop_wp),
    .drop_susp   (drop_susp)
  );

  fcd_mode_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mode (
    .clk           (clk),
    .rst_n         (rst_n),
    .grant         (grant),
    .seq_abort     (seq_abort),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .prog_go       (prog_go),
    .sec_erase_go  (sec_erase_go),
    .blk_erase_go  (blk_erase_go),
    .chip_erase_go (chip_erase_go),
    .suspend_go    (suspend_go),
    .resume_go     (resume_go),
    .tgt_addr      (tgt_addr),
    .tgt_data      (tgt_data),
    .mode          (mode_q),
    .susp_active   (susp_active),
    .erase_kind    (erase_kind),
    .erase_addr    (erase_addr)
  );

  assign mode = mode_q;

  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && arr_busy) |=> !(prog_go || sec_erase_go || blk_erase_go || chip_erase_go || resume_go)); // R8

  AST_BUSY_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    arr_busy |=> (mode == $past(mode))); // R8

  AST_WP_NO_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wp_n) |=> !chip_erase_go); // R10

  AST_WP_BOOT_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    ((prog_go || sec_erase_go || blk_erase_go) && !$past(wp_n))
      |-> !in_boot(32'(tgt_addr), ADDR_W, BLOCK_LSB, BOOT_TOP)); // R10

  AST_WP_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_wp || drop_susp) |=> !(prog_go || sec_erase_go || blk_erase_go || chip_erase_go)); // R12

  AST_RESUME_NEEDS_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    resume_go |-> $past(susp_active)); // R6

  AST_CHIP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_go |-> (tgt_addr == CHIP_A)); // R4

endmodule

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        wp_n = 1'b1;
  logic        arr_busy = 1'b0;
  logic        arr_erasing = 1'b0;
  logic        prog_go, sec_erase_go, blk_erase_go, chip_erase_go, suspend_go, resume_go;
  logic [19:0] tgt_addr;
  logic [15:0] tgt_data;
  logic [1:0]  mode;
  logic        susp_active;

  always #10 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wp_n(wp_n), .arr_busy(arr_busy), .arr_erasing(arr_erasing),
    .prog_go(prog_go), .sec_erase_go(sec_erase_go), .blk_erase_go(blk_erase_go),
    .chip_erase_go(chip_erase_go), .suspend_go(suspend_go), .resume_go(resume_go),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data), .mode(mode), .susp_active(susp_active)
  );

  // kinds: 0 program, 1 sector, 2 block, 3 chip, 4 suspend, 5 resume
  typedef struct {
    int          kind;
    logic [19:0] a;
    logic [15:0] d;
    string       req;
  } exp_t;

  exp_t  exp_q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_up();
  end

  // Monitor: pops the scoreboard whenever a start pulse appears.
  always @(negedge clk) begin
    if (rst_n) begin
      logic [5:0] s;
      exp_t       e;
      s = {resume_go, suspend_go, chip_erase_go, blk_erase_go, sec_erase_go, prog_go};
      if (s != 6'd0) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL %s: unexpected pulse %b addr %h, expected none", cur_req, s, tgt_addr);
        end else begin
          e = exp_q.pop_front();
          if (s != (6'd1 << e.kind) ||
              (e.kind < 4 && (tgt_addr != e.a || tgt_data != e.d))) begin
            n_bad++;
            $display("FAIL %s: pulse %b addr %h data %h, expected pulse %b addr %h data %h",
                     e.req, s, tgt_addr, tgt_data, 6'd1 << e.kind, e.a, e.d);
          end
        end
      end
    end
  end

  task automatic expect_op(input int kind, input logic [19:0] a, input logic [15:0] d, input string req);
    exp_t e;
    e.kind = kind; e.a = a; e.d = d; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic unlock(input logic [7:0] cmd);
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
    wr(20'h05555, {8'h00, cmd});
  endtask

  task automatic erase_prefix();
    unlock(8'h80);
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
  endtask

  task automatic drain(input string req);
    repeat (2) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL %s: %0d expected pulse(s) never seen, expected 0 pending", req, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic check_val(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: %s = %h, expected %h", req, what, act, expv);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_val("R1", "pulses", {26'd0, resume_go, suspend_go, chip_erase_go, blk_erase_go, sec_erase_go, prog_go}, 0);
    check_val("R1", "mode", 32'(mode), 0);
    check_val("R1", "susp_active", 32'(susp_active), 0);
    check_val("R1", "tgt_addr", 32'(tgt_addr), 0);
    check_val("R1", "tgt_data", 32'(tgt_data), 0);

    // R2 word program
    cur_req = "R2";
    unlock(8'hA0);
    expect_op(0, 20'h12345, 16'hBEEF, "R2");
    wr(20'h12345, 16'hBEEF);
    drain("R2");

    // R11 high byte ignored in command cycles
    cur_req = "R11";
    wr(20'h05555, 16'hC3AA);
    wr(20'h02AAA, 16'h0155);
    wr(20'h05555, 16'hFFA0);
    expect_op(0, 20'h0ABCD, 16'h1234, "R11");
    wr(20'h0ABCD, 16'h1234);
    drain("R11");

    // R3 sector and block erase
    cur_req = "R3";
    erase_prefix();
    expect_op(1, 20'h23800, 16'h0030, "R3");
    wr(20'h23800, 16'h0030);
    erase_prefix();
    expect_op(2, 20'h48000, 16'h0050, "R3");
    wr(20'h48000, 16'h0050);
    drain("R3");

    // R4 chip erase, and wrong address
    cur_req = "R4";
    erase_prefix();
    expect_op(3, 20'h05555, 16'h0010, "R4");
    wr(20'h05555, 16'h0010);
    erase_prefix();
    wr(20'h01234, 16'h0010);
    drain("R4");

    // R7 identification and query modes
    cur_req = "R7";
    unlock(8'h90);
    check_val("R7", "mode after ID entry", 32'(mode), 1);
    wr(20'h00777, 16'h00F0);
    check_val("R7", "mode after F0 exit", 32'(mode), 0);
    unlock(8'h98);
    check_val("R7", "mode after prefixed query", 32'(mode), 2);
    unlock(8'hF0);
    check_val("R7", "mode after prefixed exit", 32'(mode), 0);
    wr(20'h00055, 16'h0098);
    check_val("R7", "mode after one-write query", 32'(mode), 2);
    wr(20'h00000, 16'h00F0);
    check_val("R7", "mode after exit", 32'(mode), 0);

    // R9 abort of a broken sequence
    cur_req = "R9";
    unlock(8'h90);
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAB, 16'h0055);
    check_val("R9", "mode after abort", 32'(mode), 0);
    unlock(8'h77);
    erase_prefix();
    wr(20'h05555, 16'h0099);
    drain("R9");
    unlock(8'hA0);
    expect_op(0, 20'h00F00, 16'h5A5A, "R9");
    wr(20'h00F00, 16'h5A5A);
    drain("R9");

    // R8 busy gating
    cur_req = "R8";
    arr_busy = 1'b1;
    unlock(8'hA0);
    wr(20'h03000, 16'h1111);
    wr(20'h00055, 16'h0098);
    check_val("R8", "mode unchanged while busy", 32'(mode), 0);
    arr_busy = 1'b0;
    wr(20'h00055, 16'h0098);
    arr_busy = 1'b1;
    wr(20'h00000, 16'h00F0);
    check_val("R8", "exit ignored while busy", 32'(mode), 2);
    arr_busy = 1'b0;
    wr(20'h00000, 16'h00F0);
    drain("R8");
    wr(20'h05555, 16'h00AA);
    arr_busy = 1'b1;
    wr(20'h01234, 16'h0077);
    arr_busy = 1'b0;
    wr(20'h02AAA, 16'h0055);
    wr(20'h05555, 16'h00A0);
    expect_op(0, 20'h00321, 16'h4455, "R8");
    wr(20'h00321, 16'h4455);
    drain("R8");

    // R10 write protect of the boot block
    cur_req = "R10";
    wp_n = 1'b0;
    unlock(8'hA0);
    wr(20'h00100, 16'h0001);
    erase_prefix();
    wr(20'h00800, 16'h0030);
    erase_prefix();
    wr(20'h07000, 16'h0050);
    erase_prefix();
    wr(20'h05555, 16'h0010);
    drain("R10");
    unlock(8'hA0);
    expect_op(0, 20'h08000, 16'h0002, "R10");
    wr(20'h08000, 16'h0002);
    wp_n = 1'b1;
    erase_prefix();
    expect_op(3, 20'h05555, 16'h0010, "R10");
    wr(20'h05555, 16'h0010);
    drain("R10");

    // R5 suspend, R12 suspended region, R6 resume (sector)
    cur_req = "R5";
    wr(20'h00000, 16'h00B0);
    check_val("R5", "susp_active after idle B0", 32'(susp_active), 0);
    erase_prefix();
    expect_op(1, 20'h23800, 16'h0030, "R5");
    wr(20'h23800, 16'h0030);
    arr_busy = 1'b1; arr_erasing = 1'b1;
    expect_op(4, 20'h0, 16'h0, "R5");
    wr(20'h00000, 16'h00B0);
    check_val("R5", "susp_active after suspend", 32'(susp_active), 1);
    arr_busy = 1'b0; arr_erasing = 1'b0;
    drain("R5");
    cur_req = "R12";
    unlock(8'hA0);
    wr(20'h23A00, 16'h0003);
    erase_prefix();
    wr(20'h60000, 16'h0030);
    drain("R12");
    unlock(8'hA0);
    expect_op(0, 20'h24000, 16'h0004, "R12");
    wr(20'h24000, 16'h0004);
    drain("R12");
    cur_req = "R6";
    expect_op(5, 20'h0, 16'h0, "R6");
    wr(20'h00777, 16'h0030);
    check_val("R6", "susp_active after resume", 32'(susp_active), 0);
    wr(20'h00777, 16'h0030);
    drain("R6");

    // R5 B0 during a program is ignored
    cur_req = "R5";
    arr_busy = 1'b1;
    wr(20'h00000, 16'h00B0);
    arr_busy = 1'b0;
    check_val("R5", "susp_active after B0 during program", 32'(susp_active), 0);
    drain("R5");

    // R12 block suspension
    cur_req = "R12";
    erase_prefix();
    expect_op(2, 20'h48000, 16'h0050, "R12");
    wr(20'h48000, 16'h0050);
    arr_busy = 1'b1; arr_erasing = 1'b1;
    expect_op(4, 20'h0, 16'h0, "R12");
    wr(20'h01000, 16'h00B0);
    arr_busy = 1'b0; arr_erasing = 1'b0;
    unlock(8'hA0);
    wr(20'h4F000, 16'h0005);
    drain("R12");
    unlock(8'hA0);
    expect_op(0, 20'h50000, 16'h0006, "R12");
    wr(20'h50000, 16'h0006);
    expect_op(5, 20'h0, 16'h0, "R6");
    wr(20'h00000, 16'h0030);
    drain("R12");
    check_val("R6", "susp_active after block resume", 32'(susp_active), 0);

    finish_up();
  end

endmodule